// File: doc/BRIEF.md
# Training Synapse Cell for a Systolic Perceptron Array

This block is a single synapse cell for a systolic multilayer-perceptron array that learns on chip. The cell owns a private weight store. The store is addressed by the index of the neuron on the adjacent layer. The cell carries two running sums through the array. The forward sum gathers weight × activation on its way toward the neurons of the next layer. The backward sum gathers weight × delta, which forms the error handed back to the layer before.

Each backward strobe also adjusts the addressed weight on-line. The adjustment adds a pre-scaled learning-rate × delta byte times the activation that the same pattern brought in earlier. Accepted activations wait in a small FIFO inside the cell until the delta of their pattern arrives. This pairs each delta with its own activation even when several patterns are in flight.

A mode input picks between two schedules:

- **Pipelined:** a forward step for a new pattern and a backward step for an older pattern are accepted in the same cycle.
- **Alternating:** at most one pattern is outstanding, and the two phases never overlap.

Top module: `trn_synapse`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both valid outputs are 0 and both sum outputs are 0. Every weight is 0 and the activation FIFO is empty.
- R2: When `ld_en` is 1 in a cycle, `ld_data` is written to weight `ld_addr`, and a forward step in the next cycle uses it. If a weight update targets the same address in that cycle, the loaded value wins.
- R3: An accepted forward step drives `fwd_out_vld` = 1 one cycle later, with `fwd_acc_out` = sat(`fwd_acc_in` + sat(W[`fwd_addr`] × `fwd_act`)). All values are two's complement. sat clamps to the signed 16-bit range.
- R4: A backward strobe drives `bwd_out_vld` = 1 one cycle later, with `bwd_err_out` = sat(`bwd_err_in` + sat(W[`bwd_addr`] × `bwd_delta`)).
- R5: A backward strobe with a non-empty FIFO pops the oldest activation a. It writes W[`bwd_addr`] = sat(W + floor(`bwd_eta_delta` × a / 2^UPD_SHIFT)), where UPD_SHIFT defaults to 4. The result saturates, it never wraps.
- R6: Popped activations leave the FIFO in the order their forward steps were accepted.
- R7: When a forward step and an update hit the same address in one cycle, both sums use the weight from before the update.
- R8: With `pipe_mode` = 1, forward and backward strobes are both accepted in one cycle. A forward step is refused only when the FIFO is full and no backward strobe pops in that cycle.
- R9: With `pipe_mode` = 0, a forward step is accepted only when the FIFO is empty and `bwd_vld` = 0. A refused forward step gives `fwd_out_vld` = 0 and pushes nothing.
- R10: A backward strobe with an empty FIFO still produces its error sum and leaves every weight unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | 1 = pipelined schedule, 0 = alternating |
| fwd_vld | input | 1 | Forward step strobe |
| fwd_addr | input | AW | Weight index for the forward step |
| fwd_act | input | ACT_W | Signed incoming activation |
| fwd_acc_in | input | ACC_W | Signed forward partial sum in |
| fwd_acc_out | output | ACC_W | Signed forward partial sum out, registered |
| fwd_out_vld | output | 1 | Forward result valid |
| bwd_vld | input | 1 | Backward step strobe |
| bwd_addr | input | AW | Weight index for the backward step and update |
| bwd_delta | input | ACT_W | Signed incoming delta |
| bwd_eta_delta | input | ACT_W | Signed learning-rate × delta, pre-scaled |
| bwd_err_in | input | ACC_W | Signed backward error sum in |
| bwd_err_out | output | ACC_W | Signed backward error sum out, registered |
| bwd_out_vld | output | 1 | Backward result valid |
| ld_en | input | 1 | Weight load strobe |
| ld_addr | input | AW | Weight index to load |
| ld_data | input | WGT_W | Weight value to load |

## Verification
The assertions check four rules on every cycle:
- A result appears exactly one cycle after each accepted step, and a refused forward step stays silent.
- The FIFO occupancy moves by pushes minus pops and never exceeds its depth.
- The alternating schedule never accepts a forward step while a pattern is outstanding.
- A single update never moves a weight further than the largest scaled learning-rate product.

The exact saturated sums, the pairing of each delta with its own activation, the read-before-write ordering on a shared address and load-over-update priority depend on data history. Only the bench's scenarios show these. They sweep addresses, operand extremes and both schedules against an arithmetic model.

// File: rtl/trn_pkg.sv
package trn_pkg;

  localparam int WIDE = 40;
  typedef logic signed [WIDE-1:0] wide_t;

  typedef enum logic {
    SCHED_ALT  = 1'b0,
    SCHED_PIPE = 1'b1
  } sched_e;

  // clamp a wide signed value into a signed field of the given width
  function automatic wide_t clamp_to(input wide_t v, input int bits);
    wide_t hi;
    wide_t lo;
    hi = (wide_t'(1) <<< (bits - 1)) - wide_t'(1);
    lo = -hi - wide_t'(1);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // saturated product added to a running sum, both clamped
  function automatic wide_t mac_sat(input wide_t acc, input wide_t w,
                                    input wide_t x, input int bits);
    return clamp_to(acc + clamp_to(w * x, bits), bits);
  endfunction

  // on-line weight step: w + floor(etad*a / 2^shift), clamped
  function automatic wide_t upd_sat(input wide_t w, input wide_t etad,
                                    input wide_t a, input int shift,
                                    input int bits);
    return clamp_to(w + ((etad * a) >>> shift), bits);
  endfunction

endpackage

// File: rtl/trn_act_fifo.sv
module trn_act_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wp;
  logic [PW-1:0] rp;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = empty ? '0 : slot[rp];

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step_ptr(wp);
      if (pop)  rp <= step_ptr(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/trn_wgt_store.sv
module trn_wgt_store #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  input  logic          up_en,
  input  logic [AW-1:0] up_addr,
  input  logic [W-1:0]  up_data
);

  logic [W-1:0] mem [DEPTH];

  // reads see the value held before this cycle's writes
  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ld_en && ld_addr == AW'(i))      mem[i] <= ld_data;
        else if (up_en && up_addr == AW'(i)) mem[i] <= up_data;
      end
    end
  end

endmodule

// File: rtl/trn_mac.sv
module trn_mac #(
  parameter int ACC_W = 16,
  parameter int OP_W  = 8,
  parameter int W_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic signed [ACC_W-1:0] acc_in,
  input  logic signed [W_W-1:0]   w,
  input  logic signed [OP_W-1:0]  x,
  output logic signed [ACC_W-1:0] acc_out,
  output logic                    out_vld
);

  import trn_pkg::*;

  logic signed [ACC_W-1:0] nxt;

  assign nxt = ACC_W'(mac_sat(wide_t'(acc_in), wide_t'(w), wide_t'(x), ACC_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= take;
      if (take) acc_out <= nxt;
    end
  end

endmodule

// File: rtl/trn_synapse.sv
module trn_synapse #(
  parameter int ACT_W      = 8,
  parameter int WGT_W      = 16,
  parameter int ACC_W      = 16,
  parameter int DEPTH      = 256,
  parameter int FIFO_DEPTH = 8,
  parameter int UPD_SHIFT  = 4,
  localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    fwd_vld,
  input  logic [AW-1:0]           fwd_addr,
  input  logic signed [ACT_W-1:0] fwd_act,
  input  logic signed [ACC_W-1:0] fwd_acc_in,
  output logic signed [ACC_W-1:0] fwd_acc_out,
  output logic                    fwd_out_vld,
  input  logic                    bwd_vld,
  input  logic [AW-1:0]           bwd_addr,
  input  logic signed [ACT_W-1:0] bwd_delta,
  input  logic signed [ACT_W-1:0] bwd_eta_delta,
  input  logic signed [ACC_W-1:0] bwd_err_in,
  output logic signed [ACC_W-1:0] bwd_err_out,
  output logic                    bwd_out_vld,
  input  logic                    ld_en,
  input  logic [AW-1:0]           ld_addr,
  input  logic [WGT_W-1:0]        ld_data
);

  import trn_pkg::*;

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  sched_e                  sched;
  logic                    fifo_full;
  logic                    fifo_empty;
  logic [CW-1:0]           fifo_cnt;
  logic signed [ACT_W-1:0] a_prev;
  logic                    fifo_pop;
  logic                    fwd_take;
  logic                    upd_en;
  logic signed [WGT_W-1:0] w_f;
  logic signed [WGT_W-1:0] w_b;
  logic signed [WGT_W-1:0] w_new;

  assign sched    = sched_e'(pipe_mode);
  assign fifo_pop = bwd_vld && !fifo_empty;
  assign upd_en   = fifo_pop;

  // scheduling of the forward phase against the backward phase
  always_comb begin
    unique case (sched)
      SCHED_PIPE: fwd_take = fwd_vld && (!fifo_full || fifo_pop);
      default:    fwd_take = fwd_vld && !bwd_vld && fifo_empty;
    endcase
  end

  assign w_new = WGT_W'(upd_sat(wide_t'(w_b), wide_t'(bwd_eta_delta),
                                wide_t'(a_prev), UPD_SHIFT, WGT_W));

  trn_act_fifo #(.W(ACT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fwd_take),
    .pop   (fifo_pop),
    .din   (fwd_act),
    .dout  (a_prev),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  trn_wgt_store #(.W(WGT_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_addr (fwd_addr),
    .ra_data (w_f),
    .rb_addr (bwd_addr),
    .rb_data (w_b),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .up_en   (upd_en),
    .up_addr (bwd_addr),
    .up_data (w_new)
  );

  trn_mac #(.ACC_W(ACC_W), .OP_W(ACT_W), .W_W(WGT_W)) u_fwd_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (fwd_take),
    .acc_in  (fwd_acc_in),
    .w       (w_f),
    .x       (fwd_act),
    .acc_out (fwd_acc_out),
    .out_vld (fwd_out_vld)
  );

  trn_mac #(.ACC_W(ACC_W), .OP_W(ACT_W), .W_W(WGT_W)) u_bwd_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (bwd_vld),
    .acc_in  (bwd_err_in),
    .w       (w_b),
    .x       (bwd_delta),
    .acc_out (bwd_err_out),
    .out_vld (bwd_out_vld)
  );

endmodule

// File: rtl/trn_synapse_chk.sv
module trn_synapse_chk #(
  parameter int ACT_W      = 8,
  parameter int WGT_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int UPD_SHIFT  = 4,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pipe_mode,
  input logic                    bwd_vld,
  input logic                    fwd_take,
  input logic                    fifo_pop,
  input logic [CW-1:0]           fifo_cnt,
  input logic                    fwd_out_vld,
  input logic                    bwd_out_vld,
  input logic                    upd_en,
  input logic signed [WGT_W-1:0] w_b,
  input logic signed [WGT_W-1:0] w_new
);

  localparam longint STEP_LIM = ((longint'(1) << (2 * ACT_W - 2)) >>> UPD_SHIFT) + 1;

  logic signed [39:0] w_diff;
  assign w_diff = 40'(w_new) - 40'(w_b);

  p_fwd_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_take |=> fwd_out_vld);

  p_fwd_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_take |=> !fwd_out_vld);

  p_bwd_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bwd_vld |=> bwd_out_vld);

  p_fifo_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(FIFO_DEPTH));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fifo_cnt == $past(fifo_cnt) + CW'($past(fwd_take)) - CW'($past(fifo_pop)));

  p_alt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && fwd_take) |-> (fifo_cnt == '0 && !bwd_vld));

  p_upd_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (w_diff <= 40'(STEP_LIM) && w_diff >= -40'(STEP_LIM)));

endmodule

bind trn_synapse trn_synapse_chk #(
  .ACT_W(ACT_W), .WGT_W(WGT_W), .FIFO_DEPTH(FIFO_DEPTH), .UPD_SHIFT(UPD_SHIFT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pipe_mode   (pipe_mode),
  .bwd_vld     (bwd_vld),
  .fwd_take    (fwd_take),
  .fifo_pop    (fifo_pop),
  .fifo_cnt    (fifo_cnt),
  .fwd_out_vld (fwd_out_vld),
  .bwd_out_vld (bwd_out_vld),
  .upd_en      (upd_en),
  .w_b         (w_b),
  .w_new       (w_new)
);

// File: tb/sim_trn_synapse.sv
`timescale 1ns/1ps
module sim_trn_synapse;

  localparam int DP = 4;
  localparam int FD = 4;
  localparam int SH = 4;
  localparam int AW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pipe_mode = 1'b1;
  logic              fwd_vld = 1'b0;
  logic [AW-1:0]     fwd_addr = '0;
  logic signed [7:0] fwd_act = '0;
  logic signed [15:0] fwd_acc_in = '0;
  logic signed [15:0] fwd_acc_out;
  logic              fwd_out_vld;
  logic              bwd_vld = 1'b0;
  logic [AW-1:0]     bwd_addr = '0;
  logic signed [7:0] bwd_delta = '0;
  logic signed [7:0] bwd_eta_delta = '0;
  logic signed [15:0] bwd_err_in = '0;
  logic signed [15:0] bwd_err_out;
  logic              bwd_out_vld;
  logic              ld_en = 1'b0;
  logic [AW-1:0]     ld_addr = '0;
  logic [15:0]       ld_data = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int mw [DP];
  int mq [FD];
  int mcnt = 0;

  always #2 clk = ~clk;

  trn_synapse #(.DEPTH(DP), .FIFO_DEPTH(FD), .UPD_SHIFT(SH)) u0 (.*);

  function automatic int cl(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int flr(input int p);
    int d;
    d = 1 << SH;
    if (p >= 0) return p / d;
    return -((-p + d - 1) / d);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit pm,
                      input bit fv, input int fa, input int fact, input int facc,
                      input bit bv, input int ba, input int bd, input int be, input int berr,
                      input bit le, input int la, input int ld);
    bit acc_f, pop;
    int wf, wb, ap, ef, eb;
    pipe_mode = pm;
    fwd_vld = fv; fwd_addr = AW'(fa); fwd_act = 8'(fact); fwd_acc_in = 16'(facc);
    bwd_vld = bv; bwd_addr = AW'(ba); bwd_delta = 8'(bd); bwd_eta_delta = 8'(be);
    bwd_err_in = 16'(berr);
    ld_en = le; ld_addr = AW'(la); ld_data = 16'(ld);
    wf = mw[fa]; wb = mw[ba];
    pop = bv && (mcnt > 0);
    if (pm) acc_f = fv && (mcnt < FD || pop);
    else    acc_f = fv && !bv && (mcnt == 0);
    ap = pop ? mq[0] : 0;
    ef = cl(facc + cl(wf * fact));
    eb = cl(berr + cl(wb * bd));
    if (pop) begin
      for (int i = 0; i < FD - 1; i++) mq[i] = mq[i+1];
      mcnt--;
      if (!(le && la == ba)) mw[ba] = cl(wb + flr(be * ap));
    end
    if (acc_f) begin
      mq[mcnt] = fact;
      mcnt++;
    end
    if (le) mw[la] = (ld >= 32768) ? ld - 65536 : ld;
    @(negedge clk);
    chk({tag, " fwd_vld"}, int'(fwd_out_vld), int'(acc_f));
    if (acc_f) chk({tag, " fwd_sum"}, int'(fwd_acc_out), ef);
    chk({tag, " bwd_vld"}, int'(bwd_out_vld), int'(bv));
    if (bv) chk({tag, " bwd_sum"}, int'(bwd_err_out), eb);
    fwd_vld = 0; bwd_vld = 0; ld_en = 0;
  endtask

  task automatic load(input string tag, input int a, input int v);
    step(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, a, v & 16'hffff);
  endtask

  task automatic drain(input string tag);
    while (mcnt > 0) step(tag, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
  endtask

  // weight visible on the forward sum with activation 1 and zero sum in
  task automatic probe(input string tag, input int a);
    step(tag, 1, 1, a, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    drain(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int acts [6];
    int accs [4];
    int bases [3];
    int es [5];
    acts = '{-128, -1, 0, 1, 5, 127};
    accs = '{0, 1000, -32768, 32767};
    bases = '{100, 32760, -32760};
    es = '{-128, -5, 0, 9, 127};
    for (int i = 0; i < DP; i++) mw[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset fwd_vld", int'(fwd_out_vld), 0);
    chk("R1 reset bwd_vld", int'(bwd_out_vld), 0);
    chk("R1 reset fwd_sum", int'(fwd_acc_out), 0);
    chk("R1 reset bwd_sum", int'(bwd_err_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post fwd_vld", int'(fwd_out_vld), 0);
    for (int a = 0; a < DP; a++) probe("R1 zero weight", a);

    // R2 loads, then R3/R4/R8 sweep with paired strobes and no learning
    load("R2 load", 0, 32767);
    load("R2 load", 1, -32768);
    load("R2 load", 2, 300);
    load("R2 load", 3, -7);
    for (int a = 0; a < DP; a++)
      for (int x = 0; x < 6; x++)
        for (int s = 0; s < 4; s++)
          step("R3 R4 R8 sweep", 1, 1, a, acts[x], accs[s],
               1, (a + 1) % DP, acts[5 - x], 0, accs[3 - s], 0, 0, 0);
    drain("R8 drain");

    // R5/R9: alternating schedule, one pattern in flight, update sweep
    for (int b = 0; b < 3; b++)
      for (int x = 0; x < 5; x++)
        for (int e = 0; e < 5; e++) begin
          load("R5 base", 0, bases[b]);
          step("R9 alt fwd", 0, 1, 0, es[4 - x] == 0 ? 0 : acts[x], 0,
               0, 0, 0, 0, 0, 0, 0, 0);
          step("R9 alt fwd refused", 0, 1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
          step("R5 alt bwd update", 0, 0, 0, 0, 0, 1, 0, 1, es[e], 0, 0, 0, 0);
          probe("R5 weight after update", 0);
        end
    // R9: both strobes together in alternating mode refuse the forward
    step("R9 alt both", 0, 1, 2, 9, 5, 1, 2, 1, 50, 0, 0, 0, 0);
    probe("R10 weight kept", 2);

    // R6 order and R8 full refusal
    load("R6 base", 3, 0);
    for (int k = 0; k < 5; k++)
      step("R6 R8 fill", 1, 1, 1, 16 * (k + 1), 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8 full with pop", 1, 1, 1, 112, 0, 1, 3, 1, 1, 0, 0, 0, 0);
    probe("R6 first popped", 3);
    for (int k = 0; k < 3; k++) begin
      step("R6 order pop", 1, 0, 0, 0, 0, 1, 3, 1, 16, 0, 0, 0, 0);
      probe("R6 weight", 3);
    end

    // R7 same address read-before-write
    load("R7 base", 2, 1000);
    step("R7 push", 1, 1, 2, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7 same addr", 1, 1, 2, 3, 0, 1, 2, 2, 64, 0, 0, 0, 0);
    drain("R7 drain");
    probe("R7 updated", 2);

    // R2 load beats update on the same address
    step("R2 push", 0, 1, 1, 50, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 load vs update", 0, 0, 0, 0, 0, 1, 1, 1, 100, 0, 1, 1, 777);
    probe("R2 loaded wins", 1);

    // R10 backward with empty FIFO
    step("R10 empty bwd", 1, 0, 0, 0, 0, 1, 1, -3, 127, 40, 0, 0, 0);
    probe("R10 unchanged", 1);
    for (int a = 0; a < DP; a++) probe("R5 final", a);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule